// File: doc/BRIEF.md
# Programmable Interval Timer

This block holds three independent 16-bit down-counters behind a byte-wide write port with four addresses. Offsets 0, 1 and 2 are the data addresses of counters 0, 1 and 2. Offset 3 is the control address. Software first writes a control word. The control word picks a counter, sets how that counter's divisor bytes arrive, chooses the waveform, and selects binary or BCD counting. Software then sends the divisor bytes to that counter's data address.

All counters advance on a shared count enable, `tick_en`, which stands for the slow input clock. Each counter divides that rate by its divisor. It drives either a one-tick low pulse once per period (rate generator) or a waveform that is roughly half high and half low (square wave). Output 0 is meant to serve as a periodic interrupt request for a system tick. For example, control byte 0x36 followed by a low and then a high divisor byte on offset 0 sets counter 0 to a binary square wave.

Top module: `interval_timer`

## Requirements
- R1: While reset is asserted, and after it is released, every output is high and every counter is idle. The reset configuration is low-then-high access, rate generator, binary.
- R2: A write to offset 3 is a control word. Bits 7:6 select the counter (value 3 selects none). Bits 5:4 select the access mode. Bits 3:1 hold the mode. Bit 0 selects BCD. A write to offset 0, 1 or 2 loads divisor bytes into that counter only, and the other counters keep running unchanged.
- R3: A control word is ignored when its access field is 0 or its mode field is 0, 1, 4 or 5. A counter that receives such a word keeps its waveform.
- R4: A legal control word stops the selected counter, forces its output high on the next clock, and resets its byte sequence so the next byte is taken as the low byte. The output stays high until the last divisor byte has been written.
- R5: Access mode 3 takes the low byte and then the high byte. Access mode 1 takes only the low byte, with the high byte zero. Access mode 2 takes only the high byte, with the low byte zero.
- R6: The divisor is loaded into the counter on the first tick after its last byte is written. In rate-generator mode the output first goes low after exactly N ticks, counted from the write.
- R7: In rate-generator mode (mode 2) the output is low for exactly one tick in every N ticks, for N of at least 2.
- R8: In square-wave mode (mode 3) the output is high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R9: With the BCD bit set, the divisor is read as four decimal digits. For example, 0x0012 divides by 12.
- R10: A divisor of 0 divides by 65536 in binary and by 10000 in BCD.
- R11: Mode values 6 and 7 behave exactly like modes 2 and 3.
- R12: Counters move only on clocks where `tick_en` is high. With `tick_en` low and no write, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one pulse per input-clock period |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 2 | Write address: 0 to 2 data, 3 control |
| wdata | input | 8 | Write data byte |
| tmr_out | output | NUM_CH | Counter outputs, bit 0 is the tick request |

## Verification
The properties assume that a rate-generator divisor is never 1. They also assume that a final divisor byte does not land in the same cycle as the tick that would load an earlier pending divisor. The directed stimulus keeps every mode-2 divisor at 2 or more and writes bytes on whole clock cycles. The frozen-output and pulse-width properties hold only on cycles with no write, so the bench checks the waveforms only after programming has finished.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int DIGITS = CNT_W / 4;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_LOHI = 2'd3
    } access_e;

    typedef struct packed {
        access_e             acc;
        logic                square;
        logic                bcd;
        logic                hi_next;
        logic [BYTE_W-1:0]   lo_byte;
        logic [CNT_W-1:0]    staged;
        logic [CNT_W-1:0]    active;
        logic                pend;
        logic                run;
        logic [CNT_W-1:0]    cnt;
        logic                out;
    } chan_state_t;

    // Count down by one; a BCD value wraps from 0000 to 9999.
    function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic borrow;
        if (!bcd) return v - 1'b1;
        r = v;
        borrow = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (borrow) begin
                if (r[d*4 +: 4] == 4'd0) begin
                    r[d*4 +: 4] = 4'd9;
                end else begin
                    r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // floor(N/2) in the counter's own number system; 0 stands for the full range.
    function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic [4:0] acc;
        logic carry;
        if (v == '0) begin
            r = '0;
            if (bcd) r[CNT_W-1 -: 4] = 4'd5;
            else     r[CNT_W-1] = 1'b1;
            return r;
        end
        if (!bcd) return v >> 1;
        r = '0;
        carry = 1'b0;
        for (int d = DIGITS - 1; d >= 0; d--) begin
            acc = {1'b0, v[d*4 +: 4]} + (carry ? 5'd10 : 5'd0);
            r[d*4 +: 4] = acc[4:1];
            carry = acc[0];
        end
        return r;
    endfunction
endpackage

// File: rtl/itimer_chan.sv
module itimer_chan
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ctrl_we,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic              out
);
    chan_state_t s_d, s_q;
    logic        legal;
    logic [CNT_W-1:0] half;

    // Mode values 2,3,6,7 all carry a one in mode bit 1 (wdata[2]).
    assign legal = (wdata[5:4] != 2'd0) && wdata[2];

    always_comb begin
        s_d  = s_q;
        half = '0;
        if (ctrl_we && legal) begin
            s_d.acc     = access_e'(wdata[5:4]);
            s_d.square  = wdata[1];
            s_d.bcd     = wdata[0];
            s_d.hi_next = 1'b0;
            s_d.pend    = 1'b0;
            s_d.run     = 1'b0;
            s_d.out     = 1'b1;
        end else begin
            if (tick_en) begin
                if (s_q.pend) begin
                    s_d.active = s_q.staged;
                    s_d.cnt    = s_q.staged;
                    s_d.run    = 1'b1;
                    s_d.pend   = 1'b0;
                end else if (s_q.run) begin
                    s_d.cnt = (s_q.cnt == CNT_W'(1)) ? s_q.active
                                                      : count_dec(s_q.cnt, s_q.bcd);
                end
            end
            if (data_we) begin
                unique case (s_q.acc)
                    ACC_LO: begin
                        s_d.staged = {{(CNT_W-BYTE_W){1'b0}}, wdata};
                        s_d.pend   = 1'b1;
                    end
                    ACC_HI: begin
                        s_d.staged = {wdata, {(CNT_W-BYTE_W){1'b0}}};
                        s_d.pend   = 1'b1;
                    end
                    ACC_LOHI: begin
                        if (!s_q.hi_next) begin
                            s_d.lo_byte = wdata;
                            s_d.hi_next = 1'b1;
                        end else begin
                            s_d.staged  = {wdata, s_q.lo_byte};
                            s_d.hi_next = 1'b0;
                            s_d.pend    = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            half = half_of(s_d.active, s_d.bcd);
            if (!s_d.run)         s_d.out = 1'b1;
            else if (s_d.square)  s_d.out = (s_d.cnt == '0) || (s_d.cnt > half);
            else                  s_d.out = (s_d.cnt != CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.acc     <= ACC_LOHI;
            s_q.out     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign out = s_q.out;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itimer_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [NUM_CH-1:0] tmr_out
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (addr == CTRL_ADDR);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic sel_ctrl, sel_data;
        assign sel_ctrl = ctrl_hit && (wdata[7:6] == 2'(i));
        assign sel_data = wr_en && (addr == ADDR_W'(i));

        itimer_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .ctrl_we (sel_ctrl),
            .data_we (sel_data),
            .wdata   (wdata),
            .out     (tmr_out[i])
        );
    end
endmodule

// File: rtl/itimer_checker.sv
module itimer_checker #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [7:0]        wdata,
    input logic [NUM_CH-1:0] tmr_out
);
    logic [NUM_CH-1:0] rate_q;
    logic              legal_ctrl;

    assign legal_ctrl = wr_en && (addr == 2'd3) && (wdata[5:4] != 2'd0) && wdata[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '1;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (legal_ctrl && (wdata[7:6] == 2'(i))) rate_q[i] <= !wdata[1];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_high_r1: assert (tmr_out == '1)
                else $error("outputs not high in reset");
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
        p_ctrl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (legal_ctrl && (wdata[7:6] == 2'(i))) |=> tmr_out[i]);

        p_rate_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_en && !tmr_out[i] && rate_q[i] && !wr_en) |=> tmr_out[i]);

        p_fall_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(tmr_out[i]) |-> $past(tick_en));

        p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick_en && !wr_en) |=> $stable(tmr_out[i]));
    end
endmodule

bind interval_timer itimer_checker #(.NUM_CH(NUM_CH)) u_itimer_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .tmr_out (tmr_out)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;
    localparam int LIM = 70000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [2:0] tmr_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    interval_timer #(.NUM_CH(3)) i_interval_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .tmr_out (tmr_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called at a negedge; measures one full low phase then one full high phase.
    task automatic measure(input int ch, input int exp_hi, input int exp_lo, input string req);
        int lo = 0, hi = 0, guard = 0;
        while (tmr_out[ch] == 1'b0 && guard < LIM) begin @(negedge clk); guard++; end
        while (tmr_out[ch] == 1'b1 && guard < LIM) begin @(negedge clk); guard++; end
        while (tmr_out[ch] == 1'b0 && guard < LIM) begin lo++; @(negedge clk); guard++; end
        guard = 0;
        while (tmr_out[ch] == 1'b1 && guard < LIM) begin hi++; @(negedge clk); guard++; end
        chk(req, "low ticks", lo, exp_lo);
        chk(req, "high ticks", hi, exp_hi);
    endtask

    // High samples counted from the negedge right after the final byte write.
    task automatic high_until_low(input int ch, input int exp, input string req);
        int n = 0;
        while (tmr_out[ch] == 1'b1 && n < LIM) begin n++; @(negedge clk); end
        chk(req, "high samples before first low", n, exp);
    endtask

    task automatic stays_high(input int ch, input int cycles, input string req);
        int bad = 0;
        for (int k = 0; k < cycles; k++) begin
            if (tmr_out[ch] != 1'b1) bad++;
            @(negedge clk);
        end
        chk(req, "low samples while unloaded", bad, 0);
    endtask

    task automatic t_reset;
        chk("R1", "outputs in reset", int'(tmr_out), 7);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "outputs after reset", int'(tmr_out), 7);
    endtask

    task automatic t_square_even;           // 0x36: ch0, lo/hi, mode 3, binary
        wr(2'd3, 8'h36); wr(2'd0, 8'd10); wr(2'd0, 8'd0);
        measure(0, 5, 5, "R8");
    endtask

    task automatic t_rate_start;            // 0x74: ch1, lo/hi, mode 2
        wr(2'd3, 8'h74); wr(2'd1, 8'd7); wr(2'd1, 8'd0);
        high_until_low(1, 7, "R6");
        measure(1, 6, 1, "R7");
        measure(0, 5, 5, "R2");             // ch0 unaffected
    endtask

    task automatic t_square_odd;            // 0xB6: ch2 mode 3
        wr(2'd3, 8'hB6); wr(2'd2, 8'd7); wr(2'd2, 8'd0);
        measure(2, 4, 3, "R8");
    endtask

    task automatic t_access_modes;
        wr(2'd3, 8'h14); wr(2'd0, 8'd6);    // low byte only, mode 2
        measure(0, 5, 1, "R5");
        wr(2'd3, 8'h26); wr(2'd0, 8'h01);   // high byte only -> 256, mode 3
        measure(0, 128, 128, "R5");
    endtask

    task automatic t_bcd;
        wr(2'd3, 8'h77); wr(2'd1, 8'h12); wr(2'd1, 8'h00);  // BCD 12, mode 3
        measure(1, 6, 6, "R9");
        wr(2'd3, 8'h75); wr(2'd1, 8'h10); wr(2'd1, 8'h00);  // BCD 10, mode 2
        measure(1, 9, 1, "R9");
    endtask

    task automatic t_alias;
        wr(2'd3, 8'h3C); wr(2'd0, 8'd5); wr(2'd0, 8'd0);    // mode 6
        measure(0, 4, 1, "R11");
        wr(2'd3, 8'h3E); wr(2'd0, 8'd6); wr(2'd0, 8'd0);    // mode 7
        measure(0, 3, 3, "R11");
    endtask

    task automatic t_ignored;
        wr(2'd3, 8'h3C); wr(2'd0, 8'd5); wr(2'd0, 8'd0);
        wr(2'd3, 8'h30);                    // mode 0
        wr(2'd3, 8'h04);                    // access 0
        wr(2'd3, 8'hF6);                    // counter select 3
        measure(0, 4, 1, "R3");
    endtask

    task automatic t_restart;
        wr(2'd0, 8'h09);                    // half a sequence
        wr(2'd3, 8'h34);
        stays_high(0, 20, "R4");
        wr(2'd0, 8'd4);
        stays_high(0, 20, "R4");
        wr(2'd0, 8'd0);
        high_until_low(0, 4, "R4");
        measure(0, 3, 1, "R6");
    endtask

    task automatic t_freeze;
        logic [2:0] snap;
        int changes = 0;
        @(negedge clk); tick_en = 1'b0;
        @(negedge clk); snap = tmr_out;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tmr_out != snap) changes++;
        end
        chk("R12", "output changes without ticks", changes, 0);
        tick_en = 1'b1;
        measure(0, 3, 1, "R12");
    endtask

    task automatic t_zero;
        wr(2'd3, 8'hB5); wr(2'd2, 8'h00); wr(2'd2, 8'h00);  // BCD 0 -> 10000
        measure(2, 9999, 1, "R10");
        wr(2'd3, 8'hB6); wr(2'd2, 8'h00); wr(2'd2, 8'h00);  // binary 0 -> 65536
        measure(2, 32768, 32768, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_square_even();
        t_rate_start();
        t_square_odd();
        t_access_modes();
        t_bcd();
        t_alias();
        t_ignored();
        t_restart();
        t_freeze();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule